// File: doc/BRIEF.md
# Multi-mode BERT pattern generator

This block is a serial test-pattern source for bit-error-rate testing. It sends one pattern bit for each bit slot in which the per-slot transmit enable is high. When the enable is low, the pattern state is frozen. Surrounding framing logic can therefore spread one continuous pattern over any chosen set of channel time slots and bit positions, contiguous or not. The block has no knowledge of frames.

A load pulse captures the configuration: a mode code, a 32-bit pattern word and an alternating-word repeat setting. The engine offers five maximal-length pseudorandom sequences, one of them with the zero-run limit of the quasi-random signal source. It also offers a repeating user word sent least significant bit first, and an alternation between two 16-bit words that swap after a programmed number of words.

Top module: `bert_patgen`

## Requirements
- R1: After reset, and until the first load, `tx_bit` is 0 whatever `tx_en` does.
- R2: A high `load` at a clock edge samples `mode`, `pat_word` and `alt_words` and restarts the pattern. For every valid mode, the first bit output after the load equals `pat_word[0]`.
- R3: Mode codes 0, 1, 2 and 3 select pseudorandom sequences of length N = 7, 9, 11 and 15.
  - The state s is loaded from `pat_word[N-1:0]`, and the output is s[0].
  - On each advance, the state shifts right by one, and the new s[N-1] = s[0] XOR s[t], with t = 1, 4, 2 and 1 respectively.
  - With an all-ones seed, one full period of 2^N-1 bits holds 2^(N-1) ones.
- R4: Mode code 4 (QRSS) runs the same scheme with N = 20 and t = 3.
  - The output is forced to 1 while the 14 most recent raw state bits advanced out since the load were all zero.
  - No run of more than 14 consecutive zero output bits ever appears.
- R5: Mode code 5 repeats `pat_word` with period 32, least significant bit first. For example, 5AD6B5ADh yields the bits 1,0,1,1,0 first.
- R6: Mode code 6 alternates between two 16-bit words, each sent least significant bit first.
  - The first word is `pat_word[15:0]` and the second is `pat_word[31:16]`.
  - Each word is sent `alt_words`+1 times (1 to 256) before the other word takes over. The first word is used first after a load.
- R7: In a cycle where `tx_en` is low and `load` is low, the pattern does not advance. `tx_bit` is unchanged in the next cycle.
- R8: Mode code 7 outputs 0 on every slot.
- R9: Changes on `pat_word`, `mode` or `alt_words` without a load have no effect on the bit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Synchronous pulse that captures the configuration and restarts the pattern |
| mode | input | 3 | Pattern mode code (0-3 PRBS, 4 QRSS, 5 repeat, 6 alternate, 7 off) |
| pat_word | input | WORD_W | Pattern word, seed or word pair |
| alt_words | input | CNT_W | Alternating-word repeat count minus one |
| tx_en | input | 1 | Bit-slot enable; the pattern advances only when high |
| tx_bit | output | 1 | Pattern bit for the current slot |

## Verification
The pseudorandom modes are driven with an all-ones seed, once under continuous enable and once under a sparse enable. This shows that gated slots hold the sequence rather than skip it. A full PRBS9 period is counted for ones, which checks the tap choice without depending on any model. QRSS is started from a seed of 1, which forces a 19-zero raw run at once and so separates the zero-run limit from the plain LFSR. The repeat mode uses the 5-bit example word, and the pattern word is altered mid-run without a load. The alternate mode runs repeat settings of 1, 50 and 256 words, covering both count boundaries and the swap back to the first word.

// File: rtl/bert_pkg.sv
package bert_pkg;
  typedef enum logic [2:0] {
    PM_PRBS7  = 3'd0,
    PM_PRBS9  = 3'd1,
    PM_PRBS11 = 3'd2,
    PM_PRBS15 = 3'd3,
    PM_QRSS   = 3'd4,
    PM_REPEAT = 3'd5,
    PM_ALT    = 3'd6,
    PM_OFF    = 3'd7
  } pat_mode_e;

  localparam int LFSR_W   = 20;
  localparam int QRSS_RUN = 14;
endpackage

// File: rtl/bert_lfsr.sv
module bert_lfsr
  import bert_pkg::*;
#(
  parameter int RUN = QRSS_RUN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  pat_mode_e         mode,
  input  logic [LFSR_W-1:0] seed,
  output logic              out_bit
);
  localparam int RUN_W = $clog2(RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN);

  logic [LFSR_W-1:0] st_q, st_d;
  logic [RUN_W-1:0]  zrun_q, zrun_d;
  logic              raw;

  assign raw     = st_q[0];
  assign out_bit = raw | ((mode == PM_QRSS) && (zrun_q == RUN_MAX));

  always_comb begin
    st_d   = st_q;
    zrun_d = zrun_q;
    if (load) begin
      st_d   = seed;
      zrun_d = '0;
    end else if (adv) begin
      unique case (mode)
        PM_PRBS7:  st_d[6:0]  = {st_q[0] ^ st_q[1], st_q[6:1]};
        PM_PRBS9:  st_d[8:0]  = {st_q[0] ^ st_q[4], st_q[8:1]};
        PM_PRBS11: st_d[10:0] = {st_q[0] ^ st_q[2], st_q[10:1]};
        PM_PRBS15: st_d[14:0] = {st_q[0] ^ st_q[1], st_q[14:1]};
        PM_QRSS:   st_d       = {st_q[0] ^ st_q[3], st_q[LFSR_W-1:1]};
        default:   st_d       = st_q;
      endcase
      if (raw)                   zrun_d = '0;
      else if (zrun_q < RUN_MAX) zrun_d = zrun_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      zrun_q <= '0;
    end else if (load || adv) begin
      st_q   <= st_d;
      zrun_q <= zrun_d;
    end
  end
endmodule

// File: rtl/bert_word_engine.sv
module bert_word_engine #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              alt_mode,
  input  logic [WORD_W-1:0] pat,
  input  logic [CNT_W-1:0]  words_m1,
  output logic              out_bit
);
  localparam int PTR_W = $clog2(WORD_W);
  localparam int IDX_W = PTR_W - 1;
  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  logic [WORD_W-1:0] pat_q, pat_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CNT_W-1:0]  lim_q, lim_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic              sel_q, sel_d;
  logic [PTR_W-1:0]  rd_idx;

  assign rd_idx  = alt_mode ? {sel_q, ptr_q[IDX_W-1:0]} : ptr_q;
  assign out_bit = pat_q[rd_idx];

  always_comb begin
    pat_d  = pat_q;
    ptr_d  = ptr_q;
    lim_d  = lim_q;
    wcnt_d = wcnt_q;
    sel_d  = sel_q;
    if (load) begin
      pat_d  = pat;
      lim_d  = words_m1;
      ptr_d  = '0;
      wcnt_d = '0;
      sel_d  = 1'b0;
    end else if (adv) begin
      if (!alt_mode) begin
        ptr_d = ptr_q + 1'b1;
      end else begin
        ptr_d = {1'b0, ptr_q[IDX_W-1:0] + 1'b1};
        if (ptr_q[IDX_W-1:0] == IDX_LAST) begin
          if (wcnt_q == lim_q) begin
            wcnt_d = '0;
            sel_d  = ~sel_q;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '0;
      ptr_q  <= '0;
      lim_q  <= '0;
      wcnt_q <= '0;
      sel_q  <= 1'b0;
    end else if (load || adv) begin
      pat_q  <= pat_d;
      ptr_q  <= ptr_d;
      lim_q  <= lim_d;
      wcnt_q <= wcnt_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
  import bert_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        mode,
  input  logic [WORD_W-1:0] pat_word,
  input  logic [CNT_W-1:0]  alt_words,
  input  logic              tx_en,
  output logic              tx_bit
);
  logic [1:0] rs_q;
  logic       rst_core_n;
  pat_mode_e  mode_q, mode_d;
  logic       adv;
  logic       lfsr_bit, word_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign adv    = tx_en & ~load;
  assign mode_d = load ? pat_mode_e'(mode) : mode_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) mode_q <= PM_OFF;
    else if (load)   mode_q <= mode_d;
  end

  bert_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (load),
    .adv     (adv),
    .mode    (mode_q),
    .seed    (pat_word[LFSR_W-1:0]),
    .out_bit (lfsr_bit)
  );

  bert_word_engine #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (load),
    .adv      (adv),
    .alt_mode (mode_q == PM_ALT),
    .pat      (pat_word),
    .words_m1 (alt_words),
    .out_bit  (word_bit)
  );

  always_comb begin
    unique case (mode_q)
      PM_PRBS7, PM_PRBS9, PM_PRBS11, PM_PRBS15, PM_QRSS: tx_bit = lfsr_bit;
      PM_REPEAT, PM_ALT:                                 tx_bit = word_bit;
      default:                                           tx_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bert_patgen_chk.sv
module bert_patgen_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              tx_en,
  input logic              tx_bit,
  input logic [2:0]        mode,
  input logic [2:0]        mode_q,
  input logic [WORD_W-1:0] pat_word
);
  logic [4:0] zeros_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             zeros_q <= '0;
    else if (load)                          zeros_q <= '0;
    else if (tx_en && mode_q == 3'd4) begin
      if (tx_bit)              zeros_q <= '0;
      else if (zeros_q != '1)  zeros_q <= zeros_q + 1'b1;
    end
  end

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !load) |=> $stable(tx_bit));

  a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode != 3'd7) |=> (tx_bit == $past(pat_word[0])));

  a_r8_off_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == 3'd7) |=> !tx_bit);

  a_r4_zero_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    zeros_q <= 5'd14);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd7) |-> !tx_bit);
endmodule

bind bert_patgen bert_patgen_chk #(.WORD_W(WORD_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .load     (load),
  .tx_en    (tx_en),
  .tx_bit   (tx_bit),
  .mode     (mode),
  .mode_q   (mode_q),
  .pat_word (pat_word)
);

// File: tb/bert_patgen_tb.sv
`timescale 1ns/1ps
module bert_patgen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [31:0] pat_word = '0;
  logic [7:0]  alt_words = '0;
  logic        tx_en = 1'b0;
  logic        tx_bit;

  always #4 clk = ~clk;

  bert_patgen dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .mode(mode),
    .pat_word(pat_word), .alt_words(alt_words), .tx_en(tx_en), .tx_bit(tx_bit)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  bit    exp_q[$];
  string tag_q[$];
  int    ones_cnt = 0;
  bit    done = 1'b0;

  // bench reference state
  logic [19:0] m_st;
  int          m_zr;
  logic [2:0]  m_mode = 3'd7;
  logic [31:0] m_pat;
  int          m_lim, m_ptr, m_wcnt;
  bit          m_sel;

  function automatic bit m_out();
    case (m_mode)
      3'd0, 3'd1, 3'd2, 3'd3: return m_st[0];
      3'd4: return m_st[0] | (m_zr >= 14);
      3'd5: return m_pat[m_ptr];
      3'd6: return m_pat[(m_sel ? 16 : 0) + m_ptr];
      default: return 1'b0;
    endcase
  endfunction

  task automatic m_adv();
    int n, t;
    logic [19:0] tmp;
    bit fb;
    case (m_mode)
      3'd0: begin n = 7;  t = 1; end
      3'd1: begin n = 9;  t = 4; end
      3'd2: begin n = 11; t = 2; end
      3'd3: begin n = 15; t = 1; end
      default: begin n = 20; t = 3; end
    endcase
    if (m_mode <= 3'd4) begin
      if (m_st[0]) m_zr = 0; else m_zr++;
      tmp = m_st;
      fb = tmp[0] ^ tmp[t];
      for (int k = 0; k < n - 1; k++) m_st[k] = tmp[k+1];
      m_st[n-1] = fb;
    end else if (m_mode == 3'd5) begin
      m_ptr = (m_ptr + 1) % 32;
    end else if (m_mode == 3'd6) begin
      if (m_ptr == 15) begin
        m_ptr = 0;
        if (m_wcnt == m_lim) begin m_wcnt = 0; m_sel = ~m_sel; end
        else m_wcnt++;
      end else m_ptr++;
    end
  endtask

  task automatic do_load(input logic [2:0] md, input logic [31:0] pw, input logic [7:0] aw);
    @(posedge clk); #1;
    load = 1'b1; tx_en = 1'b0; mode = md; pat_word = pw; alt_words = aw;
    m_mode = md; m_pat = pw; m_st = pw[19:0]; m_zr = 0;
    m_lim = aw; m_ptr = 0; m_wcnt = 0; m_sel = 1'b0;
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  // gap: 0 = every cycle enabled, otherwise one idle slot after each enabled slot group
  task automatic run_bits(input int nbits, input int gap, input string tag);
    int sent = 0;
    int cyc = 0;
    while (sent < nbits) begin
      @(posedge clk); #1;
      if (gap != 0 && (cyc % (gap + 1)) == gap) tx_en = 1'b0;
      else begin
        tx_en = 1'b1;
        exp_q.push_back(m_out());
        tag_q.push_back(sent == 0 ? {tag, "/R2"} : tag);
        m_adv();
        sent++;
      end
      cyc++;
    end
    @(posedge clk); #1;
    tx_en = 1'b0;
  endtask

  task automatic check_val(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    if (rst_n && tx_en) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty actual=%0d expected=none", tx_bit);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string g = tag_q.pop_front();
        if (tx_bit !== e) begin
          n_fail++;
          $display("FAIL %s actual=%0d expected=%0d", g, tx_bit, e);
        end
      end
      if (tx_bit === 1'b1) ones_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: quiet before first load, with enable toggling
    m_mode = 3'd7;
    run_bits(12, 1, "R1");

    // R3: PRBS7 continuous, PRBS9 full-period ones count
    do_load(3'd0, 32'hFFFF_FFFF, 8'd0);
    run_bits(300, 0, "R3");
    do_load(3'd1, 32'hFFFF_FFFF, 8'd0);
    @(negedge clk); ones_cnt = 0;
    run_bits(511, 0, "R3");
    @(negedge clk); #1;
    check_val("R3 prbs9 ones per period", ones_cnt, 256);

    // R7: sparse enable holds state
    do_load(3'd2, 32'hFFFF_FFFF, 8'd0);
    run_bits(400, 2, "R7");
    do_load(3'd3, 32'hFFFF_FFFF, 8'd0);
    run_bits(400, 1, "R7");

    // R4: QRSS seed 1 exposes zero-run limit; then all-ones seed
    do_load(3'd4, 32'h0000_0001, 8'd0);
    run_bits(400, 0, "R4");
    do_load(3'd4, 32'hFFFF_FFFF, 8'd0);
    run_bits(3000, 3, "R4");

    // R5: repeated 5-bit word; R9: input changes without load
    do_load(3'd5, 32'h5AD6_B5AD, 8'd0);
    run_bits(40, 0, "R5");
    @(posedge clk); #1;
    pat_word = 32'h1234_5678; mode = 3'd0; alt_words = 8'd3;
    run_bits(60, 1, "R9");

    // R6: alternation at 1, 50 and 256 words
    do_load(3'd6, 32'hA5C3_0F01, 8'd0);
    run_bits(100, 0, "R6");
    do_load(3'd6, 32'h7E7E_0000, 8'd49);
    run_bits(3300, 0, "R6");
    do_load(3'd6, 32'hFFFF_0000, 8'd255);
    run_bits(8300, 0, "R6");

    // R8: off code
    do_load(3'd7, 32'hFFFF_FFFF, 8'd0);
    run_bits(40, 0, "R8");

    // R2: restart mid-pattern
    do_load(3'd0, 32'h0000_007E, 8'd0);
    run_bits(20, 0, "R2");

    @(negedge clk); #1;
    check_val("R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule